// File: doc/BRIEF.md
# Parallel Three-Phase LED Lane Waveform Generator

This block serialises data for up to sixteen single-wire addressable RGB LED strings at once. Every lane shares one bit period. The block reads a stream of bit-plane words, where bit i of a word is the next data bit for lane i. A single tick counter splits each period into three phases:
- At tick 0 every enabled lane rises.
- At one third of the period the lanes carrying a 0 fall.
- At two thirds of the period every lane falls.

With the default 48 MHz clock, a 60-tick period gives the 800 kHz line rate. The falls then land at 20 and 40 ticks.

A frame starts on a start pulse. The lane mask and the word count are captured at that moment. The frame has three parts: one all-low pad period, then one data period per word, then one all-low pad period. After the frame, a `done` pulse marks its end. The lines then rest low for a latch gap of at least `GAP_TICKS` cycles before another frame may begin. A start pulse that arrives while a frame runs, or inside the gap, is remembered and takes effect as soon as the gap expires.

Words arrive over a valid/ready stream into a one-entry slot. `wd_ready` depends only on internal state and never on `wd_valid`. A word transfers on any clock edge where both are high. The producer may hold `wd_valid` low for as long as it likes; the block only counts the lateness. If the slot is empty at the start of a data period, the block raises `underrun` and sends a 0-code on all enabled lanes in that period. A late word is then used in the next period.

Top module: `led_lane_wavegen`

## Requirements
- R1: In every data period, each enabled lane is high during ticks 0 to ZERO_FALL-1. Period j's tick 0 appears on `lane_out` PERIOD_TICKS*(j+1)+1 clock edges after the edge that accepts the start.
- R2: A lane whose current data bit is 0 is low from tick ZERO_FALL to the end of the period.
- R3: A lane whose current bit is 1 stays high until tick ONE_FALL-1. From tick ONE_FALL to the end of the period, every lane is low.
- R4: Bit i of a data word drives `lane_out[i]`. A lane that is clear in the captured mask is never high.
- R5: A frame is one all-low pad period, then `word_count` data periods, then one all-low pad period. A count of 0 is legal and gives a frame of the two pad periods only. All lanes are low whenever `busy` is low.
- R6: `busy` is high from the edge that accepts a start until the edge that ends the trailing pad period. That same edge raises `done` for exactly one cycle, so `done` appears on the first cycle with `busy` low.
- R7: A new frame is accepted no earlier than GAP_TICKS edges after the edge that raised `done`. A start pulse seen while busy or during the gap is held and accepted exactly on that edge.
- R8: `wd_ready` is high only while the frame is in its leading pad or data periods, the slot is empty, and fewer than `word_count` words have been accepted in this frame. A word transfers on an edge where `wd_valid` and `wd_ready` are both high.
- R9: If the slot is empty at the edge that starts a data period, `underrun` pulses for one cycle and that period carries a 0-code on all enabled lanes. This includes a word that transfers on that very edge. The late word is used one period later, the frame length does not change, and any word still unused at the frame's end is discarded.
- R10: Changes to `lane_en` or `word_count` after the accepting edge have no effect on the running frame.
- R11: During and after reset, all outputs are low, the block is idle, and a start is accepted on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick of the bit timer |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Frame request pulse |
| lane_en | input | LANES | Lanes to drive, captured at frame accept |
| word_count | input | CW | Data words in the frame, captured at frame accept |
| wd_valid | input | 1 | Producer offers a bit-plane word |
| wd_ready | output | 1 | Slot can take a word this edge |
| wd_data | input | LANES | Bit-plane word, bit i for lane i |
| lane_out | output | LANES | Registered LED line outputs |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at frame end |
| underrun | output | 1 | One-cycle pulse when a data period started without a word |

## Verification
The delicate coincidence is a word transfer that lands on the same edge that opens a data period. The word is accepted into the slot, but the period must still be zero-filled and flagged, and the word must appear one period later. The bench provokes this by withholding one chosen word until exactly the period-start edge. It then compares every lane cycle by cycle against a waveform built from the shifted word order, and checks the cycle in which `underrun` pulses. A second coincidence, a start held from the busy phase plus a fresh start pulse inside the gap, is judged by the edge on which `busy` rises again.

// File: rtl/led_wave_pkg.sv
package led_wave_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_DATA,
    ST_TRAIL,
    ST_GAP
  } frame_st_t;
endpackage

// File: rtl/led_bit_timer.sv
// Shared tick counter for all lanes; produces the two phase windows.
module led_bit_timer #(
  parameter int PERIOD_TICKS = 60,
  parameter int ZERO_FALL    = 20,
  parameter int ONE_FALL     = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic last_tick,
  output logic hi_all,
  output logic hi_one
);
  localparam int PW = $clog2(PERIOD_TICKS);
  localparam logic [PW-1:0] LAST_T = PW'(PERIOD_TICKS - 1);
  localparam logic [PW-1:0] ZF_T   = PW'(ZERO_FALL);
  localparam logic [PW-1:0] OF_T   = PW'(ONE_FALL);

  logic [PW-1:0] tick_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                tick_q <= '0;
    else if (!run || last_tick) tick_q <= '0;
    else                       tick_q <= tick_q + 1'b1;
  end

  assign last_tick = run && (tick_q == LAST_T);
  assign hi_all    = tick_q < ZF_T;
  assign hi_one    = tick_q < OF_T;
endmodule

// File: rtl/led_word_slot.sv
// One-entry holding slot on the valid/ready word stream.
module led_word_slot #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         allow,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         take,
  input  logic         flush,
  output logic         full,
  output logic [W-1:0] data
);
  logic         full_q;
  logic [W-1:0] data_q;

  assign in_ready = allow && !full_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (flush || take) begin
      full_q <= 1'b0;
    end else if (in_valid && in_ready) begin
      full_q <= 1'b1;
      data_q <= in_data;
    end
  end

  assign full = full_q;
  assign data = data_q;
endmodule

// File: rtl/led_lane_driver.sv
// Per-lane current bit and registered line output.
module led_lane_driver #(
  parameter int LANES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LANES-1:0] load_word,
  input  logic             in_data,
  input  logic [LANES-1:0] mask,
  input  logic             hi_all,
  input  logic             hi_one,
  output logic [LANES-1:0] lane_out
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic bit_q;
    logic out_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bit_q <= 1'b0;
        out_q <= 1'b0;
      end else begin
        if (load) bit_q <= load_word[i];
        out_q <= in_data && mask[i] && (hi_all || (hi_one && bit_q));
      end
    end
    assign lane_out[i] = out_q;
  end
endmodule

// File: rtl/led_frame_ctrl.sv
// Frame sequencing: pads, data periods, latch gap, held start.
module led_frame_ctrl
  import led_wave_pkg::*;
#(
  parameter int CW        = 12,
  parameter int GAP_TICKS = 2400
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] word_count,
  input  logic          last_tick,
  input  logic          slot_full,
  input  logic          word_hs,
  output frame_st_t     state,
  output logic          accept,
  output logic          load,
  output logic          flush,
  output logic          fetch_open,
  output logic          busy,
  output logic          done,
  output logic          underrun
);
  localparam int GW = $clog2(GAP_TICKS);
  localparam logic [GW-1:0] GAP_LAST = GW'(GAP_TICKS - 1);

  frame_st_t     st_q, st_d;
  logic [CW-1:0] cnt_q, left_q, fetched_q;
  logic [GW-1:0] gap_q;
  logic          pend_q, done_q, under_q;
  logic          gap_last;

  assign gap_last = (st_q == ST_GAP) && (gap_q == GAP_LAST);
  assign accept   = ((st_q == ST_IDLE) && start) ||
                    (gap_last && (pend_q || start));
  assign load     = last_tick && (((st_q == ST_LEAD) && (cnt_q != '0)) ||
                                  ((st_q == ST_DATA) && (left_q > CW'(1))));
  assign flush    = last_tick && (((st_q == ST_LEAD) && (cnt_q == '0)) ||
                                  ((st_q == ST_DATA) && (left_q == CW'(1))));
  assign busy     = (st_q == ST_LEAD) || (st_q == ST_DATA) || (st_q == ST_TRAIL);
  assign fetch_open = ((st_q == ST_LEAD) || (st_q == ST_DATA)) && (fetched_q < cnt_q);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (accept) st_d = ST_LEAD;
      ST_LEAD:  if (last_tick) st_d = (cnt_q == '0) ? ST_TRAIL : ST_DATA;
      ST_DATA:  if (flush) st_d = ST_TRAIL;
      ST_TRAIL: if (last_tick) st_d = ST_GAP;
      ST_GAP:   if (gap_last) st_d = accept ? ST_LEAD : ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      left_q    <= '0;
      fetched_q <= '0;
      gap_q     <= '0;
      pend_q    <= 1'b0;
      done_q    <= 1'b0;
      under_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      done_q  <= (st_q == ST_TRAIL) && last_tick;
      under_q <= load && !slot_full;

      if (accept) begin
        cnt_q  <= word_count;
        left_q <= word_count;
      end else if ((st_q == ST_DATA) && last_tick) begin
        left_q <= left_q - 1'b1;
      end

      if (accept)       fetched_q <= '0;
      else if (word_hs) fetched_q <= fetched_q + 1'b1;

      if (st_q == ST_GAP) gap_q <= gap_q + 1'b1;
      else                gap_q <= '0;

      if (accept)                        pend_q <= 1'b0;
      else if (start && st_q != ST_IDLE) pend_q <= 1'b1;
    end
  end

  assign state    = st_q;
  assign done     = done_q;
  assign underrun = under_q;
endmodule

// File: rtl/led_lane_wavegen.sv
module led_lane_wavegen
  import led_wave_pkg::*;
#(
  parameter int LANES        = 16,
  parameter int PERIOD_TICKS = 60,
  parameter int ZERO_FALL    = 20,
  parameter int ONE_FALL     = 40,
  parameter int GAP_TICKS    = 2400,
  parameter int CW           = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LANES-1:0] lane_en,
  input  logic [CW-1:0]    word_count,
  input  logic             wd_valid,
  output logic             wd_ready,
  input  logic [LANES-1:0] wd_data,
  output logic [LANES-1:0] lane_out,
  output logic             busy,
  output logic             done,
  output logic             underrun
);
  frame_st_t        state;
  logic             accept, load, flush, fetch_open;
  logic             last_tick, hi_all, hi_one;
  logic             slot_full;
  logic [LANES-1:0] slot_data;
  logic [LANES-1:0] lane_mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      lane_mask_q <= '0;
    else if (accept) lane_mask_q <= lane_en;
  end

  led_bit_timer #(
    .PERIOD_TICKS(PERIOD_TICKS), .ZERO_FALL(ZERO_FALL), .ONE_FALL(ONE_FALL)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .run(busy),
    .last_tick(last_tick), .hi_all(hi_all), .hi_one(hi_one)
  );

  led_frame_ctrl #(.CW(CW), .GAP_TICKS(GAP_TICKS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .word_count(word_count),
    .last_tick(last_tick), .slot_full(slot_full),
    .word_hs(wd_valid && wd_ready),
    .state(state), .accept(accept), .load(load), .flush(flush),
    .fetch_open(fetch_open), .busy(busy), .done(done), .underrun(underrun)
  );

  led_word_slot #(.W(LANES)) u_slot (
    .clk(clk), .rst_n(rst_n), .allow(fetch_open),
    .in_valid(wd_valid), .in_ready(wd_ready), .in_data(wd_data),
    .take(load && slot_full), .flush(flush),
    .full(slot_full), .data(slot_data)
  );

  led_lane_driver #(.LANES(LANES)) u_drv (
    .clk(clk), .rst_n(rst_n), .load(load),
    .load_word(slot_full ? slot_data : '0),
    .in_data(state == ST_DATA), .mask(lane_mask_q),
    .hi_all(hi_all), .hi_one(hi_one), .lane_out(lane_out)
  );
endmodule

// File: rtl/led_lane_wavegen_chk.sv
module led_lane_wavegen_chk #(
  parameter int LANES     = 16,
  parameter int GAP_TICKS = 2400
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LANES-1:0] lane_out,
  input logic [LANES-1:0] lane_mask_q,
  input logic             busy,
  input logic             done,
  input logic             underrun,
  input logic             wd_ready
);
  localparam int QW = $clog2(GAP_TICKS + 1);
  logic [QW-1:0] quiet_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                       quiet_q <= QW'(GAP_TICKS);
    else if (done)                    quiet_q <= '0;
    else if (quiet_q < QW'(GAP_TICKS)) quiet_q <= quiet_q + 1'b1;
  end

  AST_MASKED_LANES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_out & ~lane_mask_q) == '0);  // R4
  AST_IDLE_LINES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> lane_out == '0);  // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R6
  AST_DONE_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));  // R6
  AST_LATCH_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> quiet_q >= QW'(GAP_TICKS - 1));  // R7
  AST_READY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    wd_ready |-> busy);  // R8
  AST_UNDERRUN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> (busy && !done));  // R9
  AST_UNDERRUN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> !underrun);  // R9
endmodule

bind led_lane_wavegen led_lane_wavegen_chk #(
  .LANES(LANES), .GAP_TICKS(GAP_TICKS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lane_out(lane_out), .lane_mask_q(lane_mask_q),
  .busy(busy), .done(done), .underrun(underrun), .wd_ready(wd_ready)
);

// File: tb/sim_led_lane_wavegen.sv
module sim_led_lane_wavegen;
  localparam int CLK_PERIOD = 10;
  localparam int L  = 16;
  localparam int P  = 12;
  localparam int ZF = 4;
  localparam int OF = 8;
  localparam int G  = 40;
  localparam int CW = 8;
  localparam int WATCHDOG = 150000;

  // {lane mask, word count, seed}
  localparam logic [39:0] VEC [0:5] = '{
    {16'hFFFF, 8'd4, 16'h00A5},
    {16'h00FF, 8'd3, 16'h1234},
    {16'h8001, 8'd1, 16'hFFFF},
    {16'h5A5A, 8'd5, 16'h0F0F},
    {16'hFFFF, 8'd2, 16'h0000},
    {16'hFFFF, 8'd0, 16'h7777}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [L-1:0]  lane_en = '0;
  logic [CW-1:0] word_count = '0;
  logic          wd_valid = 1'b0;
  logic          wd_ready;
  logic [L-1:0]  wd_data = '0;
  logic [L-1:0]  lane_out;
  logic          busy, done, underrun;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  led_lane_wavegen #(
    .LANES(L), .PERIOD_TICKS(P), .ZERO_FALL(ZF), .ONE_FALL(OF),
    .GAP_TICKS(G), .CW(CW)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .lane_en(lane_en),
    .word_count(word_count), .wd_valid(wd_valid), .wd_ready(wd_ready),
    .wd_data(wd_data), .lane_out(lane_out), .busy(busy), .done(done),
    .underrun(underrun)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [L-1:0] wv(input logic [15:0] s, input int j);
    return L'((int'(s) * (j + 5)) ^ (j * 4369));
  endfunction

  // bits carried by data period j, given a late slot (-1 = none)
  function automatic logic [L-1:0] period_bits(input logic [15:0] s, input int j,
                                               input int late);
    if (late < 0 || j < late) return wv(s, j);
    if (j == late) return '0;
    return wv(s, j - 1);
  endfunction

  task automatic run_frame(input logic [L-1:0] en, input int n,
                           input logic [15:0] seed, input int late,
                           input bit scramble, input bit held);
    int widx = 0;
    bit hs = 0;
    int e1 = 0, e2 = 0, e3 = 0, e4 = 0, e5 = 0, e6 = 0, e8 = 0, e9 = 0, e7 = 0;
    int last_k = (n + 2) * P;
    @(negedge clk);
    lane_en = en; word_count = CW'(n); start = 1'b1;
    wd_valid = (widx < n) && !(late == 0 && 0 < P); wd_data = wv(seed, 0);
    hs = wd_valid && wd_ready;
    for (int k = 0; k <= last_k; k++) begin
      logic [L-1:0] got, bits, zl, ol;
      int idx;
      @(posedge clk); @(negedge clk);
      if (hs) widx++;
      start = held && (k == 3);
      if (scramble) begin lane_en = ~en; word_count = CW'(n + 3); end
      if (held && k == last_k) word_count = '0;
      got = lane_out;
      idx = k - 1 - P;
      if (idx >= 0 && idx < n * P) begin
        int t = idx % P;
        bits = period_bits(seed, idx / P, late);
        zl = en & ~bits; ol = en & bits;
        if (t < ZF) begin if (got != en) e1++; end
        else if (t < OF) begin
          if ((got & zl) != '0) e2++;
          if ((got & ol) != ol) e3++;
        end else if ((got & en) != '0) e3++;
      end else if (got != '0) e5++;
      if ((got & ~en) != '0) e4++;
      if (busy != (k < last_k) || done != (k == last_k)) e6++;
      if (underrun != (late >= 0 && late < n && k == P * (1 + late))) e9++;
      if (wd_ready && (k >= last_k || widx >= n)) e8++;
      wd_valid = (widx < n) && !(late >= 0 && widx == late && (k + 1) < P * (1 + late));
      wd_data = wv(seed, widx);
      hs = wd_valid && wd_ready;
    end
    wd_valid = 1'b0;
    check(e1 == 0, "R1", "cycles with enabled lanes not high at period start", e1, 0);
    check(e2 == 0, "R2", "cycles with a 0-code lane high past the first fall", e2, 0);
    check(e3 == 0, "R3", "cycles with a 1-code lane wrong", e3, 0);
    check(e4 == 0, "R4", "cycles with a masked lane high", e4, 0);
    check(e5 == 0, "R5", "cycles with lanes high outside data periods", e5, 0);
    check(e6 == 0, "R6", "cycles with busy/done wrong", e6, 0);
    check(e8 == 0 && widx == n, "R8", "ready violations plus word shortfall",
          e8 + (n - widx), 0);
    check(e9 == 0, "R9", "cycles with underrun wrong", e9, 0);
    if (scramble)
      check(e1 + e2 + e3 + e4 + e5 + e6 == 0, "R10", "mismatches after input change",
            e1 + e2 + e3 + e4 + e5 + e6, 0);
    // latch gap: lines low, busy low until the gap edge (or held start)
    for (int m = 1; m <= G + 1; m++) begin
      @(posedge clk); @(negedge clk);
      start = held && (m == 3);
      if (lane_out != '0) e7++;
      if (busy != (held && m >= G)) e7++;
    end
    check(e7 == 0, "R7", "gap cycles with wrong busy or lanes", e7, 0);
    if (held) begin
      int w = 0;
      while (!done && w < 4 * P) begin @(negedge clk); w++; end
      check(done == 1'b1, "R7", "held frame completed", done, 1);
      repeat (G + 2) @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    start = 1'b1;  // must be ignored during reset
    repeat (4) @(negedge clk);
    check(lane_out == '0, "R11", "lanes in reset", lane_out, 0);
    check(busy == 1'b0 && done == 1'b0, "R11", "busy/done in reset", {busy, done}, 0);
    check(underrun == 1'b0 && wd_ready == 1'b0, "R11", "underrun/ready in reset",
          {underrun, wd_ready}, 0);
    start = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R11", "idle after reset", busy, 0);

    foreach (VEC[v])
      run_frame(VEC[v][39:24], int'(VEC[v][23:16]), VEC[v][15:0], -1, 1'b0, 1'b0);

    run_frame(16'hFFFF, 4, 16'h3C3C, 2, 1'b0, 1'b0);  // R9 late mid-frame
    run_frame(16'h0F0F, 3, 16'hBEEF, 0, 1'b0, 1'b0);  // R9 first word late
    run_frame(16'h33CC, 3, 16'h1357, -1, 1'b1, 1'b0); // R10 inputs change
    run_frame(16'hFFFF, 2, 16'h2468, -1, 1'b0, 1'b1); // R7 held start

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule